// File: doc/BRIEF.md
# Genlocked Colour Subcarrier Phase and Burst Gate

This block produces the digital phase of the colour subcarrier for a composite video encoder that runs on a single 27 MHz sample clock. A phase accumulator advances by a fixed step per sample. The step is chosen for the selected television standard. The accumulator is forced back to a reference phase at the start of each colour-frame sequence, which is found from the falling edges of the incoming vertical sync. This keeps the subcarrier locked to the timing of an external sync source.

Each line, the block opens a burst gate window a fixed number of samples after the horizontal sync leading edge. The window stays open for the number of samples that spans the standard's burst cycle count. The block also reports the burst phase that the chroma modulator must use on that line. For the line-alternating standards, it keeps a per-line switch that moves the burst between its two phases. Sine lookup, modulation and DAC scaling take `phase_o`, `burst_en_o`, `burst_phase_o` and `vswitch_o` as their inputs and sit outside this block.

Top module: `subcarrier_genlock`

## Requirements
- R1: `std_sel` encodes the standard: 2'b00 is the 525-line 3.579545 MHz standard, 2'b01 is the 625-line 4.433619 MHz line-alternating standard, 2'b10 is the 525-line 3.575611 MHz line-alternating standard, and 2'b11 is sleep. In sleep, `phase_o` reads 0 one clock after the selection is sampled, `burst_en_o` stays low and `vswitch_o` is 0.
- R2: Outside a sequence start, `phase_o` advances each clock by round(f·2^32/27e6) modulo 2^32, where f is the subcarrier frequency of the selected standard.
- R3: The first `vsync_n` falling edge after reset starts a colour-frame sequence, and so does every 4th edge after it in the 2'b00 standard and every 8th edge in the two line-alternating standards. At a sequence start the accumulator is loaded with phase 0, so `phase_o` reads 0 in the clock after the edge is sampled. At any other edge it keeps advancing.
- R4: A line sample counter restarts at 0 on the clock that samples a `hsync_n` falling edge. `burst_en_o` is high while the count is at least BURST_START and below BURST_START plus the burst length. The burst length is 68 samples for 2'b00, 61 samples for 2'b01 and 68 samples for 2'b10, which is 9, 10 and 9 subcarrier cycles rounded to samples.
- R5: A line whose `hsync_n` falling edge is sampled while `vsync_n` is low carries no burst window.
- R6: In the line-alternating standards, `vswitch_o` inverts at each sampled `hsync_n` falling edge. In the 2'b00 standard and in sleep it is held at 0.
- R7: `burst_phase_o` gives the burst angle relative to the U axis in units of 360/256 degrees. It is 128 (180°) for 2'b00 and sleep. In the line-alternating standards it is 96 (135°) while `vswitch_o` is 0 and 160 (225°) while it is 1.
- R8: Without a new `hsync_n` falling edge, the line counter holds at its maximum value, so no second burst window opens.
- R9: When a sequence start and a `hsync_n` falling edge are sampled on the same clock, `vswitch_o` becomes 0.
- R10: While `rst_n` is low, `phase_o` is 0, `burst_en_o` is 0 and `vswitch_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 2 | Standard select (see R1) |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| phase_o | output | PHASE_OUT_W | Subcarrier phase word, full turn = 2^PHASE_OUT_W |
| burst_en_o | output | 1 | Burst gate window |
| burst_phase_o | output | 8 | Burst angle for the current line, 360/256 degree units |
| vswitch_o | output | 1 | Line-alternation switch state |

## Verification
The bench builds the block with a 9-bit line counter and BURST_START of 24. Accumulator width, output width, frequencies and field counts stay at their defaults. With these values the full burst window of every standard fits within a short run. Counter saturation (R8) is also reachable in a few hundred clocks, and a counter that wraps instead of holding would reopen the window at a sample the bench watches. Keeping the default 32-bit accumulator lets the bench compare the per-clock phase step of each standard exactly against its own rounding of the frequency ratio.

// File: rtl/scg_pkg.sv
package scg_pkg;

   typedef enum logic [1:0] {
      STD_NTSC  = 2'b00,
      STD_PAL   = 2'b01,
      STD_PALM  = 2'b10,
      STD_SLEEP = 2'b11
   } vid_std_e;

   // Burst angles, 360/256 degree units, relative to the U axis
   localparam logic [7:0] BPH_MID  = 8'd128;
   localparam logic [7:0] BPH_LEAD = 8'd96;
   localparam logic [7:0] BPH_LAG  = 8'd160;

   function automatic longint unsigned phase_step(input longint unsigned f_hz,
                                                  input longint unsigned clk_hz,
                                                  input int unsigned acc_w);
      return ((f_hz << acc_w) + (clk_hz >> 1)) / clk_hz;
   endfunction

   function automatic longint unsigned burst_samples(input longint unsigned cycles,
                                                     input longint unsigned clk_hz,
                                                     input longint unsigned f_hz);
      return (cycles * clk_hz + (f_hz >> 1)) / f_hz;
   endfunction

   function automatic logic alt_line(input vid_std_e s);
      return (s == STD_PAL) || (s == STD_PALM);
   endfunction

endpackage

// File: rtl/scg_sync_edges.sv
module scg_sync_edges #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_n,
   output logic [N-1:0] fall
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_line
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= lvl_n[i];
         end
         assign fall[i] = prev_q & ~lvl_n[i];
      end
   endgenerate
endmodule

// File: rtl/scg_phase_accum.sv
module scg_phase_accum
   import scg_pkg::*;
#(
   parameter int unsigned      ACC_W  = 32,
   parameter int unsigned      OUT_W  = 32,
   parameter longint unsigned  CLK_HZ = 64'd27000000,
   parameter longint unsigned  F_NTSC = 64'd3579545,
   parameter longint unsigned  F_PAL  = 64'd4433619,
   parameter longint unsigned  F_PALM = 64'd3575611,
   parameter logic [ACC_W-1:0] REF_PHASE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  vid_std_e         std,
   input  logic             seq_start,
   output logic [OUT_W-1:0] phase
);
   localparam logic [ACC_W-1:0] STEP_NTSC = ACC_W'(phase_step(F_NTSC, CLK_HZ, ACC_W));
   localparam logic [ACC_W-1:0] STEP_PAL  = ACC_W'(phase_step(F_PAL,  CLK_HZ, ACC_W));
   localparam logic [ACC_W-1:0] STEP_PALM = ACC_W'(phase_step(F_PALM, CLK_HZ, ACC_W));

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] step;

   always_comb begin
      case (std)
         STD_PAL:  step = STEP_PAL;
         STD_PALM: step = STEP_PALM;
         default:  step = STEP_NTSC;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc_q <= '0;
      else if (std == STD_SLEEP) acc_q <= '0;
      else if (seq_start)        acc_q <= REF_PHASE;
      else                       acc_q <= acc_q + step;
   end

   generate
      if (OUT_W == ACC_W) begin : g_full
         assign phase = acc_q;
      end else begin : g_trunc
         assign phase = acc_q[ACC_W-1 -: OUT_W];
      end
   endgenerate

   // R3: sequence start realigns the accumulator
   a_r3_genlock_load: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && std != STD_SLEEP) |=> (acc_q == REF_PHASE));
   // R1: sleep parks the phase at zero
   a_r1_sleep_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (std == STD_SLEEP) |=> (acc_q == '0));
endmodule

// File: rtl/scg_burst_gate.sv
module scg_burst_gate
   import scg_pkg::*;
#(
   parameter int unsigned     CNT_W       = 11,
   parameter int unsigned     BURST_START = 143,
   parameter longint unsigned CLK_HZ      = 64'd27000000,
   parameter longint unsigned F_NTSC      = 64'd3579545,
   parameter longint unsigned F_PAL       = 64'd4433619,
   parameter longint unsigned F_PALM      = 64'd3575611,
   parameter longint unsigned CYC_NTSC    = 64'd9,
   parameter longint unsigned CYC_PAL     = 64'd10,
   parameter longint unsigned CYC_PALM    = 64'd9
) (
   input  logic     clk,
   input  logic     rst_n,
   input  vid_std_e std,
   input  logic     hs_fall,
   input  logic     vs_low,
   output logic     burst_en
);
   localparam logic [CNT_W-1:0] LEN_NTSC = CNT_W'(burst_samples(CYC_NTSC, CLK_HZ, F_NTSC));
   localparam logic [CNT_W-1:0] LEN_PAL  = CNT_W'(burst_samples(CYC_PAL,  CLK_HZ, F_PAL));
   localparam logic [CNT_W-1:0] LEN_PALM = CNT_W'(burst_samples(CYC_PALM, CLK_HZ, F_PALM));
   localparam logic [CNT_W-1:0] START_C  = CNT_W'(BURST_START);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             vsl_q;
   logic [CNT_W-1:0] len;
   logic [CNT_W:0]   stop;
   logic             win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_MAX;
         vsl_q <= 1'b0;
      end else if (hs_fall) begin
         cnt_q <= '0;
         vsl_q <= vs_low;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      case (std)
         STD_PAL:  len = LEN_PAL;
         STD_PALM: len = LEN_PALM;
         default:  len = LEN_NTSC;
      endcase
   end

   assign stop     = {1'b0, START_C} + {1'b0, len};
   assign win      = (cnt_q >= START_C) && ({1'b0, cnt_q} < stop);
   assign burst_en = win && !vsl_q && (std != STD_SLEEP);

   // R4: the window is always shut on the sample after a line start
   a_r4_shut_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      hs_fall |=> !burst_en);
endmodule

// File: rtl/scg_line_switch.sv
module scg_line_switch
   import scg_pkg::*;
#(
   parameter int unsigned FIELDS_NTSC = 4,
   parameter int unsigned FIELDS_PAL  = 8,
   parameter int unsigned FIELDS_PALM = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  vid_std_e std,
   input  logic     hs_fall,
   input  logic     vs_fall,
   output logic     seq_start,
   output logic     sw
);
   localparam int unsigned FMAX_A = (FIELDS_NTSC > FIELDS_PAL) ? FIELDS_NTSC : FIELDS_PAL;
   localparam int unsigned FMAX   = (FMAX_A > FIELDS_PALM) ? FMAX_A : FIELDS_PALM;
   localparam int unsigned FW     = $clog2(FMAX + 1);

   logic [FW-1:0] fld_q;
   logic [FW-1:0] last;
   logic          armed_q;
   logic          sw_q;

   always_comb begin
      case (std)
         STD_PAL:  last = FW'(FIELDS_PAL - 1);
         STD_PALM: last = FW'(FIELDS_PALM - 1);
         default:  last = FW'(FIELDS_NTSC - 1);
      endcase
   end

   assign seq_start = vs_fall && (!armed_q || (fld_q >= last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld_q   <= '0;
         armed_q <= 1'b0;
      end else if (vs_fall) begin
         armed_q <= 1'b1;
         fld_q   <= seq_start ? '0 : fld_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              sw_q <= 1'b0;
      else if (!alt_line(std)) sw_q <= 1'b0;
      else if (seq_start)      sw_q <= 1'b0;
      else if (hs_fall)        sw_q <= ~sw_q;
   end

   assign sw = sw_q;

   // R6: each line start flips the switch in the alternating standards
   a_r6_flip_per_line: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_fall && alt_line(std) && !seq_start) |=> (sw_q != $past(sw_q)));
   // R6: non-alternating standard keeps the switch low
   a_r6_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
      (std == STD_NTSC) |=> !sw_q);
   // R9: a sequence start wins over a coincident line start
   a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> !sw_q);
endmodule

// File: rtl/subcarrier_genlock.sv
module subcarrier_genlock
   import scg_pkg::*;
#(
   parameter int unsigned     ACC_W       = 32,
   parameter int unsigned     PHASE_OUT_W = 32,
   parameter int unsigned     CNT_W       = 11,
   parameter int unsigned     BURST_START = 143,
   parameter longint unsigned CLK_HZ      = 64'd27000000,
   parameter longint unsigned F_NTSC      = 64'd3579545,
   parameter longint unsigned F_PAL       = 64'd4433619,
   parameter longint unsigned F_PALM      = 64'd3575611,
   parameter longint unsigned CYC_NTSC    = 64'd9,
   parameter longint unsigned CYC_PAL     = 64'd10,
   parameter longint unsigned CYC_PALM    = 64'd9,
   parameter int unsigned     FIELDS_NTSC = 4,
   parameter int unsigned     FIELDS_PAL  = 8,
   parameter int unsigned     FIELDS_PALM = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             std_sel,
   input  logic                   hsync_n,
   input  logic                   vsync_n,
   output logic [PHASE_OUT_W-1:0] phase_o,
   output logic                   burst_en_o,
   output logic [7:0]             burst_phase_o,
   output logic                   vswitch_o
);
   localparam longint unsigned LEN_A   = burst_samples(CYC_NTSC, CLK_HZ, F_NTSC);
   localparam longint unsigned LEN_B   = burst_samples(CYC_PAL,  CLK_HZ, F_PAL);
   localparam longint unsigned LEN_C   = burst_samples(CYC_PALM, CLK_HZ, F_PALM);
   localparam longint unsigned LEN_AB  = (LEN_A > LEN_B) ? LEN_A : LEN_B;
   localparam longint unsigned LEN_MAX = (LEN_AB > LEN_C) ? LEN_AB : LEN_C;

   initial begin
      assert (ACC_W >= 16 && ACC_W <= 36) else $error("ACC_W out of range");
      assert (PHASE_OUT_W >= 1 && PHASE_OUT_W <= ACC_W) else $error("PHASE_OUT_W too wide");
      assert (BURST_START >= 1) else $error("BURST_START must be positive");
      assert (longint'(BURST_START) + LEN_MAX < (64'd1 << CNT_W) - 1)
         else $error("burst window does not fit the line counter");
      assert (FIELDS_NTSC >= 1 && FIELDS_PAL >= 1 && FIELDS_PALM >= 1)
         else $error("field counts must be positive");
   end

   vid_std_e   std;
   logic [1:0] fall;
   logic       hs_fall;
   logic       vs_fall;
   logic       seq_start;
   logic       sw;

   assign std     = vid_std_e'(std_sel);
   assign hs_fall = fall[0];
   assign vs_fall = fall[1];

   scg_sync_edges #(.N(2)) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_n ({vsync_n, hsync_n}),
      .fall  (fall)
   );

   scg_line_switch #(
      .FIELDS_NTSC (FIELDS_NTSC),
      .FIELDS_PAL  (FIELDS_PAL),
      .FIELDS_PALM (FIELDS_PALM)
   ) u_switch (
      .clk       (clk),
      .rst_n     (rst_n),
      .std       (std),
      .hs_fall   (hs_fall),
      .vs_fall   (vs_fall),
      .seq_start (seq_start),
      .sw        (sw)
   );

   scg_phase_accum #(
      .ACC_W  (ACC_W),
      .OUT_W  (PHASE_OUT_W),
      .CLK_HZ (CLK_HZ),
      .F_NTSC (F_NTSC),
      .F_PAL  (F_PAL),
      .F_PALM (F_PALM)
   ) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .std       (std),
      .seq_start (seq_start),
      .phase     (phase_o)
   );

   scg_burst_gate #(
      .CNT_W       (CNT_W),
      .BURST_START (BURST_START),
      .CLK_HZ      (CLK_HZ),
      .F_NTSC      (F_NTSC),
      .F_PAL       (F_PAL),
      .F_PALM      (F_PALM),
      .CYC_NTSC    (CYC_NTSC),
      .CYC_PAL     (CYC_PAL),
      .CYC_PALM    (CYC_PALM)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .std      (std),
      .hs_fall  (hs_fall),
      .vs_low   (~vsync_n),
      .burst_en (burst_en_o)
   );

   always_comb begin
      if (alt_line(std)) burst_phase_o = sw ? BPH_LAG : BPH_LEAD;
      else               burst_phase_o = BPH_MID;
   end

   assign vswitch_o = sw;

   // R7: during a burst the angle is one of the three legal codes
   a_r7_burst_word: assert property (@(posedge clk) disable iff (!rst_n)
      burst_en_o |-> (burst_phase_o == 8'd96 || burst_phase_o == 8'd128 ||
                      burst_phase_o == 8'd160));
   // R5: a line begun inside vertical sync carries no burst
   a_r5_vsync_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_fall && !vsync_n) |=> !burst_en_o);
endmodule

// File: tb/sim_subcarrier_genlock.sv
module sim_subcarrier_genlock;
   localparam int CLK_PERIOD = 10;
   localparam int BS         = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  std_sel = 2'b00;
   logic        hsync_n = 1'b1;
   logic        vsync_n = 1'b1;
   logic [31:0] phase_o;
   logic        burst_en_o;
   logic [7:0]  burst_phase_o;
   logic        vswitch_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   subcarrier_genlock #(.CNT_W(9), .BURST_START(BS)) u0 (
      .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .hsync_n(hsync_n),
      .vsync_n(vsync_n), .phase_o(phase_o), .burst_en_o(burst_en_o),
      .burst_phase_o(burst_phase_o), .vswitch_o(vswitch_o)
   );

   function automatic longint unsigned exp_step(input logic [1:0] s);
      real f;
      f = (s == 2'b01) ? 4433619.0 : (s == 2'b10) ? 3575611.0 : 3579545.0;
      return longint'(f * 4294967296.0 / 27.0e6);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      hsync_n = 1'b1;
      vsync_n = 1'b1;
      rst_n   = 1'b0;
      repeat (3) tick();
      rst_n   = 1'b1;
      tick();
   endtask

   // returns first sample index with burst high and number of burst samples
   task automatic run_line(input int len, output int first, output int cnt);
      first = 0;
      cnt   = 0;
      hsync_n = 1'b0;
      for (int k = 1; k <= len; k++) begin
         tick();
         if (burst_en_o && first == 0) first = k;
         if (burst_en_o) cnt++;
         if (k == 3) hsync_n = 1'b1;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) tick();
      chk("R10 phase in reset", phase_o, 0);
      chk("R10 burst in reset", burst_en_o, 0);
      chk("R10 switch in reset", vswitch_o, 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_step(input logic [1:0] s);
      logic [31:0] p0;
      std_sel = s;
      repeat (2) tick();
      for (int i = 0; i < 3; i++) begin
         p0 = phase_o;
         tick();
         chk($sformatf("R2 phase step std=%0d", s), 32'(phase_o - p0), exp_step(s));
      end
   endtask

   task automatic t_genlock(input logic [1:0] s, input int nf, input int edges);
      logic [31:0] pb;
      longint      ex;
      do_reset();
      std_sel = s;
      for (int i = 1; i <= edges; i++) begin
         repeat (20) tick();
         pb = phase_o;
         vsync_n = 1'b0;
         tick();
         ex = (i == 1 || ((i - 1) % nf) == 0) ? 0 : longint'(32'(pb + 32'(exp_step(s))));
         chk($sformatf("R3 genlock std=%0d edge %0d", s, i), phase_o, ex);
         repeat (3) tick();
         vsync_n = 1'b1;
      end
   endtask

   task automatic t_burst(input logic [1:0] s, input int explen);
      int first, cnt;
      std_sel = s;
      vsync_n = 1'b1;
      repeat (2) tick();
      run_line(BS + 120, first, cnt);
      chk($sformatf("R4 burst open std=%0d", s), first, BS + 1);
      chk($sformatf("R4 burst length std=%0d", s), cnt, explen);
   endtask

   task automatic t_vs_line();
      int first, cnt;
      do_reset();
      std_sel = 2'b00;
      vsync_n = 1'b0;
      tick();
      run_line(BS + 120, first, cnt);
      chk("R5 no burst on vsync line", cnt, 0);
      vsync_n = 1'b1;
      tick();
      run_line(BS + 120, first, cnt);
      chk("R5 burst returns after vsync", cnt, 68);
   endtask

   task automatic t_switch();
      do_reset();
      std_sel = 2'b01;
      tick();
      chk("R7 lead angle switch 0", burst_phase_o, 96);
      for (int i = 1; i <= 4; i++) begin
         hsync_n = 1'b0;
         tick();
         chk($sformatf("R6 switch line %0d", i), vswitch_o, i % 2);
         chk($sformatf("R7 angle line %0d", i), burst_phase_o, (i % 2) ? 160 : 96);
         hsync_n = 1'b1;
         repeat (5) tick();
      end
      std_sel = 2'b00;
      hsync_n = 1'b0;
      tick();
      chk("R6 switch held low std 0", vswitch_o, 0);
      chk("R7 mid angle std 0", burst_phase_o, 128);
      hsync_n = 1'b1;
      tick();
   endtask

   task automatic t_coincide();
      do_reset();
      std_sel = 2'b10;
      tick();
      hsync_n = 1'b0;
      vsync_n = 1'b0;
      tick();
      chk("R9 switch after joint edge", vswitch_o, 0);
      chk("R3 phase at joint edge", phase_o, 0);
      hsync_n = 1'b1;
      vsync_n = 1'b1;
      repeat (3) tick();
      hsync_n = 1'b0;
      tick();
      chk("R6 switch after next line", vswitch_o, 1);
      hsync_n = 1'b1;
      tick();
   endtask

   task automatic t_sleep();
      int first, cnt;
      std_sel = 2'b11;
      repeat (2) tick();
      chk("R1 sleep phase", phase_o, 0);
      run_line(BS + 120, first, cnt);
      chk("R1 sleep burst", cnt, 0);
      chk("R1 sleep switch", vswitch_o, 0);
      chk("R7 sleep angle", burst_phase_o, 128);
   endtask

   task automatic t_saturate();
      int first, cnt;
      do_reset();
      std_sel = 2'b00;
      repeat (2) tick();
      run_line(800, first, cnt);
      chk("R8 single window without new line", cnt, 68);
   endtask

   initial begin
      t_reset();
      t_step(2'b00);
      t_step(2'b01);
      t_step(2'b10);
      t_genlock(2'b00, 4, 6);
      t_genlock(2'b01, 8, 10);
      do_reset();
      t_burst(2'b00, 68);
      t_burst(2'b01, 61);
      t_burst(2'b10, 68);
      t_vs_line();
      t_switch();
      t_coincide();
      t_sleep();
      t_saturate();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule